// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings up to seven independent power domains up and down in hardware. Each domain has four active-high controls: clock enable, isolation enable, reset release and power-down. The block also watches one acknowledge line per domain that comes back from the power switch. Software asks for a domain to be powered on or off by writing a bit mask through a small write port. It reads back the on state, the busy state, the sticky error flags and the raw acknowledge lines through a combinational read port.

A single sequencer serves one domain at a time. Requests that arrive while it is working are held in a per-domain pending bit and served lowest bit first.

Power-down follows this order, with a settle interval after each of the first three steps:
1. Gate the clock.
2. Raise isolation.
3. Assert reset.
4. Request power-down, then poll for the acknowledge to rise.

Power-up runs the mirror image:
1. Drop the power-down request and poll for the acknowledge to fall.
2. Release reset.
3. Drop isolation.
4. Enable the clock, followed by a final settle.

Each acknowledge wait is bounded by a poll budget, and the two directions have different budgets. When the budget runs out, the sequence stops where it is and the domain's error flag is set.

The controller has nine states:
- `ST_IDLE`: waits for a pending request.
- `ST_OFF_CLK`, `ST_OFF_ISO`, `ST_OFF_RST`: settle after each power-down step.
- `ST_OFF_ACK`: polls for the acknowledge to rise.
- `ST_ON_ACK`: polls for the acknowledge to fall.
- `ST_ON_RST`, `ST_ON_ISO`, `ST_ON_CLK`: settle after each power-up step.

The transitions are:
- `ST_IDLE` to `ST_OFF_CLK` (start off) when the lowest pending domain is on and wants to be off.
- `ST_IDLE` to `ST_ON_ACK` (start on) when the lowest pending domain is off and wants to be on.
- `ST_IDLE` to `ST_IDLE` (no-op) when that domain is already in the state it wants.
- `ST_OFF_CLK` to `ST_OFF_ISO` to `ST_OFF_RST` to `ST_OFF_ACK`, one step each time the settle timer expires.
- `ST_OFF_ACK` to `ST_IDLE` on acknowledge high (off done) or when the budget is spent (off timeout).
- `ST_ON_ACK` to `ST_ON_RST` on acknowledge low, or `ST_ON_ACK` to `ST_IDLE` when the budget is spent (on timeout).
- `ST_ON_RST` to `ST_ON_ISO` to `ST_ON_CLK` to `ST_IDLE` (on done), one step each time the settle timer expires.

Top module: `pds_sequencer`

## Requirements
- R1: After reset every domain has clock enable 1, isolation 0, reset release 1 and power-down 0, and reads as on, not busy and error-free.
- R2: A power-off request changes the outputs of the domain in this order: clock enable falls two cycles after the write cycle; isolation rises SETTLE_CYC cycles later; reset release falls SETTLE_CYC cycles after that; power-down rises SETTLE_CYC cycles after that.
- R3: A power-off completes, with the busy bit clearing, on the first poll that sees the acknowledge high. Polls are POLL_CYC cycles apart, the first one POLL_CYC cycles after power-down rises. The on-state bit clears when the sequence starts.
- R4: A power-on request clears power-down two cycles after the write. Reset release rises on the poll after the acknowledge is seen low; isolation falls SETTLE_CYC later; clock enable rises SETTLE_CYC after that. The on-state bit sets SETTLE_CYC after the clock step.
- R5: If OFF_POLLS polls in power-off all see the acknowledge low, the error bit of that domain sets on the last poll and busy clears. The domain is left with clock 0, isolation 1, reset release 0 and power-down 1, and reads as off.
- R6: If ON_POLLS polls in power-on all see the acknowledge high, the error bit sets on the last poll. No further output changes, and the domain reads as off. A later power-on request runs the rest of the sequence.
- R7: Only one domain sequence runs at a time. Requests written meanwhile set pending bits (seen as busy) and are served in ascending bit order, each starting one cycle after the previous one ends.
- R8: A request for the state a domain already has shows busy for one cycle and then completes with no output change.
- R9: Error bits are sticky. Writing 1 to a bit at address 2 clears it the next cycle; writing 0 leaves it set.
- R10: Write address 0 requests power-on for the set bits and address 1 requests power-off. Read address 0 returns on-state, 1 returns busy (pending or active), 2 returns errors and 3 returns the acknowledge inputs.
- R11: Bit position i selects domain i in every word and vector; a sequence never changes another domain's outputs, and at most one output bit changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 on, 1 off, 2 error clear) |
| wr_data | input | NUM_DOM | Domain mask for the write |
| rd_addr | input | 2 | Read address (0 on, 1 busy, 2 error, 3 ack) |
| rd_data | output | NUM_DOM | Read data, combinational |
| sw_ack | input | NUM_DOM | Power switch acknowledge, high when powered down |
| dom_clk_en | output | NUM_DOM | Clock enable per domain |
| dom_iso_en | output | NUM_DOM | Isolation enable per domain |
| dom_rst_rel | output | NUM_DOM | Reset release per domain (1 = out of reset) |
| dom_pwr_dn | output | NUM_DOM | Power-down request per domain |

## Verification
Every expected output change is scheduled at an absolute cycle derived from the write cycle:
- Start: the write is captured at the next edge and the first step lands one edge after that.
- Steps: each later step lands SETTLE_CYC edges after the previous one.
- Acknowledge: the bench's switch model delays power-down by a fixed latency, and the sequencer acts on the poll that follows.

The scoreboard compares each observed output change against both the full expected vectors and the scheduled cycle. Busy, on-state and error bits are read in the cycle just before and the cycle just after the edge where they are due to change. Timeouts are pinned to the exact poll count of each direction.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF_CLK,
        ST_OFF_ISO,
        ST_OFF_RST,
        ST_OFF_ACK,
        ST_ON_ACK,
        ST_ON_RST,
        ST_ON_ISO,
        ST_ON_CLK
    } seq_state_e;

    localparam logic [1:0] WA_ON     = 2'd0;
    localparam logic [1:0] WA_OFF    = 2'd1;
    localparam logic [1:0] WA_ERRCLR = 2'd2;

    localparam logic [1:0] RA_ON   = 2'd0;
    localparam logic [1:0] RA_BUSY = 2'd1;
    localparam logic [1:0] RA_ERR  = 2'd2;
    localparam logic [1:0] RA_ACK  = 2'd3;

endpackage

// File: rtl/pds_timer.sv
// Loadable down counter; load has priority over decrement, holds at zero.
module pds_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign is_zero = (cnt_q == '0);

    // R2: a running count never wraps past zero
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));

endmodule

// File: rtl/pds_pick.sv
// Lowest-index selector over the pending mask.
module pds_pick #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end

    // R7: chosen index is pending and no lower index is pending
    always_comb begin
        if (any) begin
            a_r7_lowest_first: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end

endmodule

// File: rtl/pds_sequencer.sv
module pds_sequencer
    import pds_pkg::*;
#(
    parameter int NUM_DOM    = 7,
    parameter int CLK_MHZ    = 100,
    parameter int SETTLE_CYC = 5 * CLK_MHZ,
    parameter int POLL_CYC   = 1,
    parameter int OFF_POLLS  = 1000,
    parameter int ON_POLLS   = 10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NUM_DOM-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [NUM_DOM-1:0] rd_data,
    input  logic [NUM_DOM-1:0] sw_ack,
    output logic [NUM_DOM-1:0] dom_clk_en,
    output logic [NUM_DOM-1:0] dom_iso_en,
    output logic [NUM_DOM-1:0] dom_rst_rel,
    output logic [NUM_DOM-1:0] dom_pwr_dn
);

    localparam int IW       = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int STEP_MAX = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
    localparam int TW       = $clog2(STEP_MAX + 1);
    localparam int TRY_MAX  = (ON_POLLS > OFF_POLLS) ? ON_POLLS : OFF_POLLS;
    localparam int PW       = $clog2(TRY_MAX + 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC - 1);
    localparam logic [PW-1:0] OFF_LD    = PW'(OFF_POLLS - 1);
    localparam logic [PW-1:0] ON_LD     = PW'(ON_POLLS - 1);

    seq_state_e         state_q, state_d;
    logic [IW-1:0]      sel_q, tgt;
    logic [NUM_DOM-1:0] want_q, pend_q, on_q, err_q;
    logic [NUM_DOM-1:0] clk_q, iso_q, rst_q, pd_q;
    logic [NUM_DOM-1:0] req_mask, clr_mask, pend_clr, err_set, active_vec;
    logic               pick_any, start, step_ld, step_zero, try_ld, try_dec, try_zero;
    logic               err_hit, on_done, sel_ack;
    logic [IW-1:0]      pick_idx;
    logic [TW-1:0]      step_val;
    logic [PW-1:0]      try_val;

    pds_pick #(.N(NUM_DOM), .IW(IW)) u_pick (
        .req (pend_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    pds_timer #(.W(TW)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (step_ld),
        .load_val (step_val),
        .dec      (1'b1),
        .is_zero  (step_zero)
    );

    pds_timer #(.W(PW)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (try_ld),
        .load_val (try_val),
        .dec      (try_dec),
        .is_zero  (try_zero)
    );

    assign sel_ack    = sw_ack[sel_q];
    assign tgt        = (state_q == ST_IDLE) ? pick_idx : sel_q;
    assign req_mask   = (wr_en && (wr_addr == WA_ON || wr_addr == WA_OFF)) ? wr_data : '0;
    assign clr_mask   = (wr_en && wr_addr == WA_ERRCLR) ? wr_data : '0;
    assign pend_clr   = start ? (NUM_DOM'(1) << pick_idx) : '0;
    assign err_set    = err_hit ? (NUM_DOM'(1) << sel_q) : '0;
    assign active_vec = (state_q != ST_IDLE) ? (NUM_DOM'(1) << sel_q) : '0;

    // Next state and step control
    always_comb begin
        state_d  = state_q;
        start    = 1'b0;
        step_ld  = 1'b0;
        step_val = SETTLE_LD;
        try_ld   = 1'b0;
        try_val  = OFF_LD;
        try_dec  = 1'b0;
        err_hit  = 1'b0;
        on_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin
                    start = 1'b1;
                    if (want_q[pick_idx] && !on_q[pick_idx]) begin
                        state_d  = ST_ON_ACK;
                        step_ld  = 1'b1;
                        step_val = POLL_LD;
                        try_ld   = 1'b1;
                        try_val  = ON_LD;
                    end else if (!want_q[pick_idx] && on_q[pick_idx]) begin
                        state_d = ST_OFF_CLK;
                        step_ld = 1'b1;
                    end
                end
            end
            ST_OFF_CLK: if (step_zero) begin state_d = ST_OFF_ISO; step_ld = 1'b1; end
            ST_OFF_ISO: if (step_zero) begin state_d = ST_OFF_RST; step_ld = 1'b1; end
            ST_OFF_RST: begin
                if (step_zero) begin
                    state_d  = ST_OFF_ACK;
                    step_ld  = 1'b1;
                    step_val = POLL_LD;
                    try_ld   = 1'b1;
                    try_val  = OFF_LD;
                end
            end
            ST_OFF_ACK: begin
                if (step_zero) begin
                    if (sel_ack) begin
                        state_d = ST_IDLE;
                    end else if (try_zero) begin
                        state_d = ST_IDLE;
                        err_hit = 1'b1;
                    end else begin
                        try_dec  = 1'b1;
                        step_ld  = 1'b1;
                        step_val = POLL_LD;
                    end
                end
            end
            ST_ON_ACK: begin
                if (step_zero) begin
                    if (!sel_ack) begin
                        state_d = ST_ON_RST;
                        step_ld = 1'b1;
                    end else if (try_zero) begin
                        state_d = ST_IDLE;
                        err_hit = 1'b1;
                    end else begin
                        try_dec  = 1'b1;
                        step_ld  = 1'b1;
                        step_val = POLL_LD;
                    end
                end
            end
            ST_ON_RST: if (step_zero) begin state_d = ST_ON_ISO; step_ld = 1'b1; end
            ST_ON_ISO: if (step_zero) begin state_d = ST_ON_CLK; step_ld = 1'b1; end
            ST_ON_CLK: if (step_zero) begin state_d = ST_IDLE; on_done = 1'b1; end
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) sel_q <= pick_idx;
        end
    end

    // Domain outputs and bookkeeping words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= '1;
            iso_q  <= '0;
            rst_q  <= '1;
            pd_q   <= '0;
            on_q   <= '1;
            want_q <= '1;
            pend_q <= '0;
            err_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | req_mask;
            err_q  <= (err_q & ~clr_mask) | err_set;
            if (wr_en && wr_addr == WA_ON)       want_q <= want_q | wr_data;
            else if (wr_en && wr_addr == WA_OFF) want_q <= want_q & ~wr_data;
            if (on_done) on_q[sel_q] <= 1'b1;
            if (state_d != state_q) begin
                case (state_d)
                    ST_OFF_CLK: begin clk_q[tgt] <= 1'b0; on_q[tgt] <= 1'b0; end
                    ST_OFF_ISO: iso_q[tgt] <= 1'b1;
                    ST_OFF_RST: rst_q[tgt] <= 1'b0;
                    ST_OFF_ACK: pd_q[tgt]  <= 1'b1;
                    ST_ON_ACK:  pd_q[tgt]  <= 1'b0;
                    ST_ON_RST:  rst_q[tgt] <= 1'b1;
                    ST_ON_ISO:  iso_q[tgt] <= 1'b0;
                    ST_ON_CLK:  clk_q[tgt] <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign dom_clk_en  = clk_q;
    assign dom_iso_en  = iso_q;
    assign dom_rst_rel = rst_q;
    assign dom_pwr_dn  = pd_q;

    always_comb begin
        unique case (rd_addr)
            RA_ON:   rd_data = on_q;
            RA_BUSY: rd_data = pend_q | active_vec;
            RA_ERR:  rd_data = err_q;
            RA_ACK:  rd_data = sw_ack;
            default: rd_data = '0;
        endcase
    end

    // R11: at most one control bit of all domains moves per cycle
    a_r11_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(clk_q ^ $past(clk_q)) + $countones(iso_q ^ $past(iso_q))
         + $countones(rst_q ^ $past(rst_q)) + $countones(pd_q ^ $past(pd_q))) <= 1);

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_chk
        // R2: isolation only rises with the clock gated
        a_r2_iso_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iso_q[i]) |-> !clk_q[i]);
        // R2: power-down only requested with clock off, isolated, in reset
        a_r2_pd_last: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pd_q[i]) |-> (iso_q[i] && !rst_q[i] && !clk_q[i]));
        // R4: reset only released with power on and acknowledge seen low
        a_r4_rst_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_q[i]) |-> (!pd_q[i] && !$past(sw_ack[i])));
        // R4: clock enabled last
        a_r4_clk_last: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_q[i]) |-> (!iso_q[i] && rst_q[i] && !pd_q[i]));
        // R5: an error only appears at the end of an acknowledge wait
        a_r5_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(err_q[i]) |-> (($past(state_q) == ST_OFF_ACK || $past(state_q) == ST_ON_ACK)
                                 && $past(sel_q) == IW'(i)));
        // R9: an error only clears on a write of 1 to its bit
        a_r9_err_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(err_q[i]) |-> $past(wr_en && wr_addr == WA_ERRCLR && wr_data[i]));
    end

endmodule

// File: tb/test_pds_sequencer.sv
module test_pds_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 7;
    localparam int S   = 4;
    localparam int OFF = 12;
    localparam int ON  = 20;
    localparam int LAT = 3;

    typedef struct packed {
        logic [31:0]  at;
        logic [N-1:0] c;
        logic [N-1:0] i;
        logic [N-1:0] r;
        logic [N-1:0] p;
    } ev_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [N-1:0] rd_data, sw_ack, o_c, o_i, o_r, o_p;
    logic [N-1:0] force_hi = '0, force_lo = '0;
    logic [N-1:0] sh [LAT];
    logic [N-1:0] m_c = '1, m_i = '0, m_r = '1, m_p = '0, m_on = '1;
    logic [4*N-1:0] prev;
    ev_t          q[$];
    string        qt[$];
    int           cyc = 0, checks = 0, failures = 0;
    bit           mon_en = 0, done = 0;

    pds_sequencer #(
        .NUM_DOM(N), .SETTLE_CYC(S), .POLL_CYC(1), .OFF_POLLS(OFF), .ON_POLLS(ON)
    ) i_pds_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sw_ack(sw_ack),
        .dom_clk_en(o_c), .dom_iso_en(o_i), .dom_rst_rel(o_r), .dom_pwr_dn(o_p)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Power switch model: acknowledge follows power-down after LAT edges
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) sh[k] <= '0;
        end else begin
            sh[0] <= o_p;
            for (int k = 1; k < LAT; k++) sh[k] <= sh[k-1];
        end
    end
    assign sw_ack = (sh[LAT-1] | force_hi) & ~force_lo;

    // Monitor: every output change must match the next expected item
    always @(negedge clk) begin
        if (mon_en && ({o_c, o_i, o_r, o_p} !== prev)) begin
            checks++;
            if (q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected change at cycle %0d: actual=%h expected=%h",
                         cyc, {o_c, o_i, o_r, o_p}, prev);
            end else begin
                ev_t e;
                string t;
                e = q.pop_front();
                t = qt.pop_front();
                if (e.at != cyc || {e.c, e.i, e.r, e.p} !== {o_c, o_i, o_r, o_p}) begin
                    failures++;
                    $display("FAIL %s R11 cycle/vectors: actual cyc=%0d %h expected cyc=%0d %h",
                             t, cyc, {o_c, o_i, o_r, o_p}, e.at, {e.c, e.i, e.r, e.p});
                end
            end
        end
        prev = {o_c, o_i, o_r, o_p};
    end

    task automatic push(input int at, input string tag);
        q.push_back('{at: at, c: m_c, i: m_i, r: m_r, p: m_p});
        qt.push_back(tag);
    endtask

    task automatic exp_off(input int d, input int e0, output int fin);
        m_c[d] = 1'b0; push(e0, "R2");
        m_i[d] = 1'b1; push(e0 + S, "R2");
        m_r[d] = 1'b0; push(e0 + 2 * S, "R2");
        m_p[d] = 1'b1; push(e0 + 3 * S, "R2");
        m_on[d] = 1'b0;
        fin = e0 + 3 * S + LAT + 1;
    endtask

    task automatic exp_on(input int d, input int e0, input int e1, output int fin);
        if (m_p[d]) begin m_p[d] = 1'b0; push(e0, "R4"); end
        m_r[d] = 1'b1; push(e1, "R4");
        m_i[d] = 1'b0; push(e1 + S, "R4");
        m_c[d] = 1'b1; push(e1 + 2 * S, "R4");
        fin = e1 + 3 * S;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [N-1:0] e, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== e) begin
            failures++;
            $display("FAIL %s read addr %0d at cycle %0d: actual=%b expected=%b",
                     tag, a, cyc, rd_data, e);
        end
    endtask

    task automatic chk_vec(input logic [N-1:0] act, input logic [N-1:0] e, input string tag);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c, e0, e1, d, d2, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 read map
        chk_vec(o_c, '1, "R1 clk_en");
        chk_vec(o_i, '0, "R1 iso_en");
        chk_vec(o_r, '1, "R1 rst_rel");
        chk_vec(o_p, '0, "R1 pwr_dn");
        chk_rd(2'd0, '1, "R1 R10 on-state");
        chk_rd(2'd1, '0, "R1 R10 busy");
        chk_rd(2'd2, '0, "R1 R10 error");
        chk_rd(2'd3, '0, "R10 ack");
        mon_en = 1;

        // R2/R3: power off domain 2
        c = cyc; e0 = c + 2;
        exp_off(2, e0, d);
        wr(2'd1, N'(1) << 2);
        wait_to(d - 1);
        chk_rd(2'd1, N'(1) << 2, "R3 busy before ack");
        chk_rd(2'd0, m_on, "R3 on-state cleared");
        wait_to(d);
        chk_rd(2'd1, '0, "R3 busy after ack");
        chk_rd(2'd2, '0, "R3 no error");
        chk_rd(2'd3, N'(1) << 2, "R10 ack readback");

        // R4: power on domain 2
        c = cyc; e0 = c + 2; e1 = e0 + LAT + 1;
        exp_on(2, e0, e1, d);
        wr(2'd0, N'(1) << 2);
        wait_to(d - 1);
        chk_rd(2'd0, m_on, "R4 on-state before final settle");
        wait_to(d);
        m_on[2] = 1'b1;
        chk_rd(2'd0, m_on, "R4 on-state set");
        chk_rd(2'd1, '0, "R4 idle");

        // R8: already on
        wr(2'd0, N'(1) << 4);
        chk_rd(2'd1, N'(1) << 4, "R8 busy one cycle");
        @(negedge clk);
        chk_rd(2'd1, '0, "R8 done at once");

        // R7: queued requests served lowest first
        c = cyc; e0 = c + 2;
        exp_off(3, e0, d);
        exp_off(1, d + 1, d2);
        exp_off(5, d2 + 1, d);
        wr(2'd1, N'(1) << 3);
        wr(2'd1, (N'(1) << 1) | (N'(1) << 5));
        chk_rd(2'd1, (N'(1) << 1) | (N'(1) << 3) | (N'(1) << 5), "R7 pending busy");
        wait_to(d);
        chk_rd(2'd1, '0, "R7 all served");
        chk_rd(2'd0, m_on, "R7 on-state");

        // R5: power-off acknowledge timeout on domain 6
        force_lo[6] = 1'b1;
        c = cyc; e0 = c + 2; p = e0 + 3 * S;
        exp_off(6, e0, d);
        wr(2'd1, N'(1) << 6);
        wait_to(p + OFF - 1);
        chk_rd(2'd2, '0, "R5 no error before limit");
        chk_rd(2'd1, N'(1) << 6, "R5 busy while polling");
        wait_to(p + OFF);
        chk_rd(2'd2, N'(1) << 6, "R5 error at limit");
        chk_rd(2'd1, '0, "R5 busy cleared");
        chk_rd(2'd0, m_on, "R5 reads off");
        chk_vec({o_c[6], o_i[6], o_r[6], o_p[6]}, 4'b0101, "R5 outputs left in off state");

        // R9: write 0 keeps, write 1 clears
        wr(2'd2, '0);
        chk_rd(2'd2, N'(1) << 6, "R9 write 0 ignored");
        wr(2'd2, N'(1) << 6);
        chk_rd(2'd2, '0, "R9 write 1 clears");

        // R6: power-on acknowledge timeout on domain 0
        force_hi[0] = 1'b1;
        c = cyc; e0 = c + 2;
        exp_off(0, e0, d);
        d = e0 + 3 * S + 1;
        wr(2'd1, N'(1) << 0);
        wait_to(d);
        chk_rd(2'd1, '0, "R3 off with early ack");
        c = cyc; e0 = c + 2;
        m_p[0] = 1'b0; push(e0, "R6");
        wr(2'd0, N'(1) << 0);
        wait_to(e0 + ON - 1);
        chk_rd(2'd2, '0, "R6 no error before limit");
        wait_to(e0 + ON);
        chk_rd(2'd2, N'(1) << 0, "R6 error at limit");
        chk_rd(2'd1, '0, "R6 busy cleared");
        chk_rd(2'd0, m_on, "R6 reads off");

        // R6 retry after release
        force_hi[0] = 1'b0;
        wr(2'd2, N'(1) << 0);
        c = cyc; e0 = c + 2; e1 = e0 + 1;
        exp_on(0, e0, e1, d);
        wr(2'd0, N'(1) << 0);
        wait_to(d);
        m_on[0] = 1'b1;
        chk_rd(2'd0, m_on, "R6 retry completes");
        chk_rd(2'd2, '0, "R9 error stays clear");

        repeat (5) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R11 missing output changes: actual=%0d expected=0", q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule